// File: doc/BRIEF.md
# Split-Transaction Bulk/Control Buffer Pool

This block holds the non-periodic buffers of a transaction translator. The high-speed side sends start-split requests, each carrying an endpoint tag and a payload word. If a buffer is free, the request is parked there and acknowledged. If none is free, it is refused with a NAK. Parked transactions are offered one at a time to a full/low-speed engine, in the order in which they were filled. The engine later reports a result word, which the pool stores against that buffer.

A complete-split query names an endpoint tag. The pool answers it with one of three things:
- "not yet", while the transaction is still waiting or is on the downstream bus;
- the stored result, after which the buffer is freed;
- a protocol error, when no buffer holds that tag.

A clear command drops whichever buffer holds a given tag. Because each buffer is keyed by its endpoint, transactions for different endpoints overlap freely.

The request ports (start-split, complete-split, clear) are accepted in every cycle and never back-pressure. Refusal is expressed by the NAK answer, and each answer appears exactly one cycle after its request. The downstream issue port is valid/ready:
- `dn_valid` rises whenever no transaction is in flight and a filled buffer exists.
- The offered tag and payload stay stable until `dn_ready` is seen, unless a clear removes that buffer.
- The transfer completes in the cycle where `dn_valid` and `dn_ready` are both high.

Results from the engine are plain single-cycle strobes.

Top module: `tt_bulk_pool`

## Requirements
- R1: After reset, every buffer reads empty on `buf_state` (code 0 = empty, 1 = filled, 2 = in flight, 3 = result ready; buffer i in bits [2i+1:2i]). In the same state, `dn_valid`, `ss_rsp_valid` and `cs_rsp_valid` are low.
- R2: A start-split is acknowledged one cycle later (`ss_rsp_valid`=1, `ss_rsp_ack`=1) when both of these hold:
  - no occupied buffer has the same tag;
  - some buffer is empty.
  Its tag and payload go into the lowest-numbered empty buffer, which becomes filled.
- R3: A start-split with no matching tag while every buffer is occupied is refused one cycle later (`ss_rsp_ack`=0) and leaves every buffer unchanged.
- R4: A start-split whose tag already occupies a buffer is acknowledged as a retry and stores nothing. Occupied buffers therefore never share a tag.
- R5: The downstream offer works as follows:
  - `dn_valid` is high exactly when no transaction is in flight and at least one buffer is filled.
  - It carries the tag and payload of the filled buffer filled earliest.
  - The handshake turns that buffer to in flight, and at most one buffer is in flight.
  - An offer not taken stays stable unless a clear intervenes.
- R6: A `res_valid` strobe while a transaction is in flight stores `res_data` in that buffer and makes it result-ready. A strobe with nothing in flight has no effect.
- R7: A complete-split whose tag matches a filled or in-flight buffer gets `cs_rsp_code`=0 (not yet) one cycle later and changes nothing.
- R8: A complete-split whose tag matches a result-ready buffer gets `cs_rsp_code`=1 with the stored result on `cs_rsp_res` one cycle later, and that buffer becomes empty.
- R9: A complete-split whose tag matches no occupied buffer gets `cs_rsp_code`=2 (protocol error) one cycle later.
- R10: A clear naming an occupied buffer's tag empties it whatever its state. If that buffer was in flight, the later result is discarded and still ends the in-flight period.
- R11: All decisions in a cycle use the buffer states from the start of that cycle. A buffer freed by a complete-split or clear is not yet free to a start-split in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_valid | input | 1 | Start-split request strobe |
| ss_ep | input | EPW | Start-split endpoint tag |
| ss_pl | input | PW | Start-split payload |
| ss_rsp_valid | output | 1 | Start-split answer present |
| ss_rsp_ack | output | 1 | 1 = ACK, 0 = NAK |
| cs_valid | input | 1 | Complete-split query strobe |
| cs_ep | input | EPW | Complete-split endpoint tag |
| cs_rsp_valid | output | 1 | Complete-split answer present |
| cs_rsp_code | output | 2 | 0 not yet, 1 result, 2 protocol error |
| cs_rsp_res | output | RW | Stored result when code is 1, else 0 |
| clr_valid | input | 1 | Clear-buffer command strobe |
| clr_ep | input | EPW | Tag of buffer to clear |
| dn_valid | output | 1 | Downstream offer valid |
| dn_ready | input | 1 | Downstream engine takes the offer |
| dn_ep | output | EPW | Offered endpoint tag |
| dn_pl | output | PW | Offered payload |
| res_valid | input | 1 | Downstream result strobe |
| res_data | input | RW | Downstream result word |
| buf_state | output | 2*NBUF | Per-buffer state codes |

## Verification
A start-split and a complete-split can land in the same cycle. The sharp case is a complete-split that frees the only result-ready buffer while every other buffer is occupied: the start-split must still be refused. A clear can likewise coincide with a downstream handshake or a result on the same buffer.

The bench provokes these collisions with a directed sequence, then mixes all five inputs at random over a small tag range so that tag matches are frequent. Each outcome is judged against a bench model that applies R11's start-of-cycle rule and the fixed priority of clear and free over every other update.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_FULL  = 2'd1,
    SL_BUSY  = 2'd2,
    SL_READY = 2'd3
  } slot_st_t;

  typedef enum logic [1:0] {
    CS_NYET = 2'd0,
    CS_DONE = 2'd1,
    CS_ERR  = 2'd2
  } cs_code_t;
endpackage

// File: rtl/ttb_slot.sv
module ttb_slot
  import ttb_pkg::*;
#(
  parameter int EPW = 4,
  parameter int PW  = 8,
  parameter int RW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fill_i,
  input  logic [EPW-1:0] ep_i,
  input  logic [PW-1:0]  pl_i,
  input  logic           issue_i,
  input  logic           done_i,
  input  logic [RW-1:0]  res_i,
  input  logic           free_i,
  input  logic           clr_i,
  output logic [1:0]     st_o,
  output logic [EPW-1:0] ep_o,
  output logic [PW-1:0]  pl_o,
  output logic [RW-1:0]  res_o
);
  slot_st_t       st_q;
  logic [EPW-1:0] ep_q;
  logic [PW-1:0]  pl_q;
  logic [RW-1:0]  res_q;

  // clear and free win over every other update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SL_EMPTY;
      ep_q  <= '0;
      pl_q  <= '0;
      res_q <= '0;
    end else if (clr_i || free_i) begin
      st_q <= SL_EMPTY;
    end else if (fill_i && st_q == SL_EMPTY) begin
      st_q <= SL_FULL;
      ep_q <= ep_i;
      pl_q <= pl_i;
    end else if (issue_i && st_q == SL_FULL) begin
      st_q <= SL_BUSY;
    end else if (done_i && st_q == SL_BUSY) begin
      st_q  <= SL_READY;
      res_q <= res_i;
    end
  end

  assign st_o  = st_q;
  assign ep_o  = ep_q;
  assign pl_o  = pl_q;
  assign res_o = res_q;

  AST_READY_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == SL_READY) |-> $past(st_q) == SL_BUSY); // R6
  AST_BUSY_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == SL_BUSY) |-> $past(st_q) == SL_FULL); // R5
endmodule

// File: rtl/ttb_age.sv
module ttb_age #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fill_i,
  input  logic [N-1:0] full_i,
  output logic [N-1:0] pick_o
);
  // older[j][i] set: buffer j was filled before buffer i
  logic [N-1:0][N-1:0] older;
  logic [N-1:0]        blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (fill_i[i]) begin
          for (int j = 0; j < N; j++) begin
            if (j != i) begin
              older[i][j] <= 1'b0;
              older[j][i] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && full_i[j] && older[j][i]) blk[i] = 1'b1;
      end
      pick_o[i] = full_i[i] && !blk[i];
    end
  end

  AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_o)); // R5
  AST_PICK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (|full_i) |-> (|pick_o)); // R5
  AST_FILL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_i)); // R2
endmodule

// File: rtl/tt_bulk_pool.sv
module tt_bulk_pool
  import ttb_pkg::*;
#(
  parameter int NBUF = 3,
  parameter int EPW  = 4,
  parameter int PW   = 8,
  parameter int RW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_valid,
  input  logic [EPW-1:0]    ss_ep,
  input  logic [PW-1:0]     ss_pl,
  output logic              ss_rsp_valid,
  output logic              ss_rsp_ack,
  input  logic              cs_valid,
  input  logic [EPW-1:0]    cs_ep,
  output logic              cs_rsp_valid,
  output logic [1:0]        cs_rsp_code,
  output logic [RW-1:0]     cs_rsp_res,
  input  logic              clr_valid,
  input  logic [EPW-1:0]    clr_ep,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [EPW-1:0]    dn_ep,
  output logic [PW-1:0]     dn_pl,
  input  logic              res_valid,
  input  logic [RW-1:0]     res_data,
  output logic [2*NBUF-1:0] buf_state
);
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;

  logic [1:0]     st_w  [NBUF];
  logic [EPW-1:0] ep_w  [NBUF];
  logic [PW-1:0]  pl_w  [NBUF];
  logic [RW-1:0]  res_w [NBUF];

  logic [NBUF-1:0] occ, empty_v, full_v, busy_v;
  logic [NBUF-1:0] ss_hit, cs_hit, clr_hit;
  logic [NBUF-1:0] fill_v, issue_v, done_v, free_v, pick_v;

  logic          has_free, cs_match;
  logic [IW-1:0] free_idx, cs_idx, pick_idx, act_idx;
  logic          act_on;
  cs_code_t      cs_code_d;

  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_slot
      assign occ[g]     = st_w[g] != SL_EMPTY;
      assign empty_v[g] = st_w[g] == SL_EMPTY;
      assign full_v[g]  = st_w[g] == SL_FULL;
      assign busy_v[g]  = st_w[g] == SL_BUSY;
      assign ss_hit[g]  = occ[g] && ep_w[g] == ss_ep;
      assign cs_hit[g]  = occ[g] && ep_w[g] == cs_ep;
      assign clr_hit[g] = clr_valid && occ[g] && ep_w[g] == clr_ep;
      assign fill_v[g]  = ss_valid && !(|ss_hit) && has_free && free_idx == IW'(g);
      assign issue_v[g] = pick_v[g] && dn_valid && dn_ready;
      assign done_v[g]  = res_valid && act_on && act_idx == IW'(g) && busy_v[g];
      assign free_v[g]  = cs_valid && cs_hit[g] && st_w[g] == SL_READY;
      assign buf_state[2*g +: 2] = st_w[g];

      ttb_slot #(.EPW(EPW), .PW(PW), .RW(RW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill_i  (fill_v[g]),
        .ep_i    (ss_ep),
        .pl_i    (ss_pl),
        .issue_i (issue_v[g]),
        .done_i  (done_v[g]),
        .res_i   (res_data),
        .free_i  (free_v[g]),
        .clr_i   (clr_hit[g]),
        .st_o    (st_w[g]),
        .ep_o    (ep_w[g]),
        .pl_o    (pl_w[g]),
        .res_o   (res_w[g])
      );
    end
  endgenerate

  ttb_age #(.N(NBUF)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .fill_i (fill_v),
    .full_i (full_v),
    .pick_o (pick_v)
  );

  // lowest-numbered empty buffer
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (empty_v[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb begin
    cs_match = |cs_hit;
    cs_idx   = '0;
    pick_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (cs_hit[i]) cs_idx = IW'(i);
      if (pick_v[i]) pick_idx = IW'(i);
    end
    if (!cs_match)                      cs_code_d = CS_ERR;
    else if (st_w[cs_idx] == SL_READY)  cs_code_d = CS_DONE;
    else                                cs_code_d = CS_NYET;
  end

  assign dn_valid = !act_on && (|pick_v);
  assign dn_ep    = ep_w[pick_idx];
  assign dn_pl    = pl_w[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_on  <= 1'b0;
      act_idx <= '0;
    end else if (dn_valid && dn_ready) begin
      act_on  <= 1'b1;
      act_idx <= pick_idx;
    end else if (res_valid) begin
      act_on  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_rsp_valid <= 1'b0;
      ss_rsp_ack   <= 1'b0;
      cs_rsp_valid <= 1'b0;
      cs_rsp_code  <= 2'd0;
      cs_rsp_res   <= '0;
    end else begin
      ss_rsp_valid <= ss_valid;
      ss_rsp_ack   <= ss_valid && ((|ss_hit) || has_free);
      cs_rsp_valid <= cs_valid;
      cs_rsp_code  <= cs_valid ? cs_code_d : CS_NYET;
      cs_rsp_res   <= (cs_valid && cs_code_d == CS_DONE) ? res_w[cs_idx] : '0;
    end
  end

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_v)); // R5
  AST_NO_OFFER_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    act_on |-> !dn_valid); // R5
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready && !clr_valid) |=> (dn_valid && $stable(dn_ep) && $stable(dn_pl))); // R5
  AST_NAK_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_valid && !(|ss_hit) && !(|empty_v)) |=> (ss_rsp_valid && !ss_rsp_ack)); // R3
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_hit)); // R4
  AST_ERR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && !(|cs_hit)) |=> (cs_rsp_valid && cs_rsp_code == 2'd2)); // R9
endmodule

// File: tb/sim_tt_bulk_pool.sv
`timescale 1ns/1ps
module sim_tt_bulk_pool;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_valid = 0, cs_valid = 0, clr_valid = 0, dn_ready = 0, res_valid = 0;
  logic [3:0] ss_ep = 0, cs_ep = 0, clr_ep = 0;
  logic [7:0] ss_pl = 0, res_data = 0;
  logic ss_rsp_valid, ss_rsp_ack, cs_rsp_valid, dn_valid;
  logic [1:0] cs_rsp_code;
  logic [7:0] cs_rsp_res, dn_pl;
  logic [3:0] dn_ep;
  logic [2*N-1:0] buf_state;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int m_st[N], m_ep[N], m_pl[N], m_res[N], m_ser[N];
  int ser_ctr = 0;
  bit m_act = 0;
  int m_idx = 0;
  bit e_ssv, e_ack, e_csv;
  int e_code, e_csd;
  string st_tag;

  always #10 clk = ~clk;

  tt_bulk_pool u0 (
    .clk(clk), .rst_n(rst_n),
    .ss_valid(ss_valid), .ss_ep(ss_ep), .ss_pl(ss_pl),
    .ss_rsp_valid(ss_rsp_valid), .ss_rsp_ack(ss_rsp_ack),
    .cs_valid(cs_valid), .cs_ep(cs_ep),
    .cs_rsp_valid(cs_rsp_valid), .cs_rsp_code(cs_rsp_code), .cs_rsp_res(cs_rsp_res),
    .clr_valid(clr_valid), .clr_ep(clr_ep),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_ep(dn_ep), .dn_pl(dn_pl),
    .res_valid(res_valid), .res_data(res_data),
    .buf_state(buf_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_state_word();
    int w = 0;
    for (int i = 0; i < N; i++) w |= (m_st[i] & 3) << (2 * i);
    return w;
  endfunction

  // one cycle: called at a negedge, returns at the next negedge
  task automatic step(input bit sv, input int se, input int sp,
                      input bit cv, input int ce,
                      input bit kv, input int ke,
                      input bit rdy, input bit rv, input int rd);
    int fi, ch, pk;
    bit sh, exp_dv, clr_i, free_i, fill_i, iss_i, done_i, collide;
    ss_valid = sv; ss_ep = se[3:0]; ss_pl = sp[7:0];
    cs_valid = cv; cs_ep = ce[3:0];
    clr_valid = kv; clr_ep = ke[3:0];
    dn_ready = rdy; res_valid = rv; res_data = rd[7:0];
    #1;
    fi = -1; ch = -1; pk = -1; sh = 0;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 0 && fi < 0) fi = i;
      if (m_st[i] != 0 && m_ep[i] == se) sh = 1;
      if (m_st[i] != 0 && m_ep[i] == ce) ch = i;
      if (m_st[i] == 1 && (pk < 0 || m_ser[i] < m_ser[pk])) pk = i;
    end
    exp_dv = !m_act && pk >= 0;
    chk(dn_valid == exp_dv, "R5 dn_valid", int'(dn_valid), int'(exp_dv));
    if (exp_dv) begin
      chk(int'(dn_ep) == m_ep[pk], "R5 oldest tag", int'(dn_ep), m_ep[pk]);
      chk(int'(dn_pl) == m_pl[pk], "R5 oldest payload", int'(dn_pl), m_pl[pk]);
    end
    e_ssv = sv; e_ack = sv && (sh || fi >= 0);
    e_csv = cv; e_csd = 0;
    if (!cv) e_code = 0;
    else if (ch < 0) e_code = 2;
    else if (m_st[ch] == 3) begin e_code = 1; e_csd = m_res[ch]; end
    else e_code = 0;
    collide = 0;
    st_tag = "R2 state";
    if (rv) st_tag = "R6 state";
    if (kv) st_tag = "R10 state";
    for (int i = 0; i < N; i++) begin
      clr_i  = kv && m_st[i] != 0 && m_ep[i] == ke;
      free_i = cv && ch == i && m_st[i] == 3;
      fill_i = sv && !sh && fi == i;
      iss_i  = exp_dv && rdy && pk == i;
      done_i = rv && m_act && m_idx == i && m_st[i] == 2;
      if ((clr_i || free_i) && sv) collide = 1;
      if (clr_i || free_i) m_st[i] = 0;
      else if (fill_i) begin m_st[i] = 1; m_ep[i] = se; m_pl[i] = sp; m_ser[i] = ser_ctr++; end
      else if (iss_i) m_st[i] = 2;
      else if (done_i) begin m_st[i] = 3; m_res[i] = rd; end
    end
    if (exp_dv && rdy) begin m_act = 1; m_idx = pk; end
    else if (rv) m_act = 0;
    @(negedge clk);
    chk(ss_rsp_valid == e_ssv, "R2 ss_rsp_valid", int'(ss_rsp_valid), int'(e_ssv));
    if (e_ssv)
      chk(ss_rsp_ack == e_ack, collide ? "R11 ss ack" : (e_ack ? (sh ? "R4 ss ack" : "R2 ss ack") : "R3 ss nak"),
          int'(ss_rsp_ack), int'(e_ack));
    chk(cs_rsp_valid == e_csv, "R7 cs_rsp_valid", int'(cs_rsp_valid), int'(e_csv));
    if (e_csv) begin
      chk(int'(cs_rsp_code) == e_code, e_code == 2 ? "R9 code" : (e_code == 1 ? "R8 code" : "R7 code"),
          int'(cs_rsp_code), e_code);
      if (e_code == 1) chk(int'(cs_rsp_res) == e_csd, "R8 result", int'(cs_rsp_res), e_csd);
    end
    chk(int'(buf_state) == model_state_word(), collide ? "R11 state" : st_tag,
        int'(buf_state), model_state_word());
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_ep[i] = 0; m_pl[i] = 0; m_res[i] = 0; m_ser[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(buf_state == '0, "R1 buf_state", int'(buf_state), 0);
    chk(!dn_valid, "R1 dn_valid", int'(dn_valid), 0);
    chk(!ss_rsp_valid && !cs_rsp_valid, "R1 responses", int'(ss_rsp_valid), 0);
    // directed: R2 fills, engine held off
    step(1, 1, 8'h11, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2, 8'h22, 0, 0, 0, 0, 0, 0, 0);
    step(1, 3, 8'h33, 0, 0, 0, 0, 0, 0, 0);
    step(1, 4, 8'h44, 0, 0, 0, 0, 0, 0, 0);   // R3 NAK, pool full
    step(1, 2, 8'h99, 1, 9, 0, 0, 0, 0, 0);   // R4 retry ACK, R9 unknown tag
    step(0, 0, 0, 1, 1, 0, 0, 1, 0, 0);       // R7 not yet; R5 ep1 issued
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 8'hA5);   // R6 result for ep1
    step(1, 5, 8'h55, 1, 1, 0, 0, 0, 0, 0);   // R8 done + R11 ss refused same cycle
    step(1, 5, 8'h55, 0, 0, 0, 0, 1, 0, 0);   // slot now free: ACK; ep2 issued
    step(0, 0, 0, 0, 0, 1, 2, 0, 0, 0);       // R10 clear in-flight ep2
    step(0, 0, 0, 1, 2, 0, 0, 0, 1, 8'h77);   // late result discarded, R9 on ep2
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h66);   // R6 stray result ignored
    step(0, 0, 0, 1, 3, 1, 5, 1, 0, 0);       // R10 clear filled ep5, ep3 issued
    // random mix
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 2) == 0, $urandom % 6, $urandom % 256,
           ($urandom % 5) < 2, $urandom % 7,
           ($urandom % 20) == 0, $urandom % 6,
           ($urandom % 2) == 0, ($urandom % 10) < 3, $urandom % 256);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule